// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit first-in first-out buffer. Its two ports run on separate clocks. A producer pushes one word on each write-clock edge where its write enable is high. A consumer pops one word on each read-clock edge where its read enable is high. The two clocks may be one net or fully unrelated.

The write pointer is passed into the read domain, and the read pointer into the write domain. Each crossing uses Gray code and a chain of synchronizer flops. Empty and almost-empty are computed in the read domain. Full, almost-full and half-full are computed in the write domain.

The two threshold offsets reset to a default value. Software can rewrite them through the data port while the load input is held high. Each offset is written in two parts. The FIFO stores no data during a load.

The read data bus has an output-enable input. The bus is not a three-state pin. It is driven to zero while disabled, and a separate enable output tells the pad logic to drive the bus.

Top module: `dcfifo_pflag`

## Requirements
- R1: After reset, empty_o and aempty_o are 1, and full_o, afull_o and half_o are 0.
- R2: Words leave in the order they entered. A pop on a read-clock edge (ren_i high, empty_o low) updates the read data on that same edge.
- R3: A write while full_o is high is dropped. No word is stored and the write pointer does not move.
- R4: A read while empty_o is high is dropped. The read data keeps its last value and the read pointer does not move.
- R5: empty_o is high when the FIFO holds no word, as seen in the read domain. full_o is high when it holds DEPTH words, as seen in the write domain.
- R6: aempty_o is high when the stored word count is at or below the almost-empty offset. The offset defaults to DEF_OFS (7).
- R7: afull_o is high when the free space (DEPTH minus the count) is at or below the almost-full offset. The offset defaults to DEF_OFS (7).
- R8: half_o is high when the count is at least DEPTH/2.
- R9: While ld_i is high, each write-enabled edge writes one offset part instead of FIFO data, in this cyclic order:
  - almost-empty low part, taken from wdata_i[LO_W-1:0];
  - almost-empty high part, taken from wdata_i[HI_W-1:0];
  - almost-full low part;
  - almost-full high part.

  LO_W is AW/2 and HI_W is AW-LO_W, where AW = log2(DEPTH); both are 4 at DEPTH=256. The order restarts at the almost-empty low part whenever ld_i is low.
- R10: While oe_i is low, rdata_o is zero and rdata_oe_o is 0. While oe_i is high, rdata_oe_o is 1 and rdata_o shows the last popped word.
- R11: Writes and reads may run concurrently on unrelated clocks without loss, duplication or reordering of words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wen_i | input | 1 | Write enable |
| ld_i | input | 1 | Offset load mode: writes go to the offset registers |
| wdata_i | input | DATA_W | Write data, or offset part during load |
| ren_i | input | 1 | Read enable |
| oe_i | input | 1 | Read bus output enable |
| rdata_o | output | DATA_W | Read data, zero while oe_i is low |
| rdata_oe_o | output | 1 | Drive enable for the read bus |
| full_o | output | 1 | FIFO holds DEPTH words (write domain) |
| empty_o | output | 1 | FIFO holds no word (read domain) |
| afull_o | output | 1 | Free space at or below the almost-full offset |
| aempty_o | output | 1 | Count at or below the almost-empty offset |
| half_o | output | 1 | Count at least DEPTH/2 |

## Verification
The bench builds the block with its defaults: DEPTH=256, DATA_W=18, a default offset of 7 and two synchronizer stages. The write clock runs at 10 ns and the read clock at an unrelated 14 ns.

With DEPTH=256, the FIFO can be filled to full and drained completely within the run. That covers:
- the half-full edge at 128 words;
- the almost-full edges at 249 words (default offset) and 254 words (loaded offset);
- writes dropped while full.

Each offset part is 4 bits wide at this depth. That lets the bench load small thresholds, and show that the part order restarts at the almost-empty low part once the load input is released.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  // offset part selected by the load sequencer
  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int DW = 18,
  parameter int AW = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // output register: updates on the same read edge as the pop
  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
  import dcfifo_pkg::*;
#(
  parameter int AW      = 8,
  parameter int DEF_OFS = 7,
  localparam int LO_W   = AW / 2,
  localparam int HI_W   = AW - LO_W
) (
  input  logic            wclk_i,
  input  logic            rst_ni,
  input  logic            wen_i,
  input  logic            ld_i,
  input  logic [HI_W-1:0] ofs_data_i,
  input  logic [AW:0]     rgray_s_i,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [AW:0]     wgray_o,
  output logic [AW-1:0]   ae_ofs_o,
  output logic            full_o,
  output logic            afull_o,
  output logic            half_o
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);
  localparam logic [AW:0] HALF_V  = (AW+1)'(1 << (AW - 1));

  logic [AW:0]   wbin_q, wgray_q, wbin_nxt, rbin_s, used, free;
  logic [AW-1:0] ae_ofs_q, af_ofs_q;
  ofs_sel_e      sel_q;
  logic          push;

  assign push     = wen_i & ~ld_i & ~full_o;
  assign wbin_nxt = wbin_q + (AW+1)'(push);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end

  always_comb begin
    for (int i = 0; i <= AW; i++) rbin_s[i] = ^(rgray_s_i >> i);
  end

  assign used    = wbin_q - rbin_s;
  assign free    = DEPTH_V - used;
  assign full_o  = (wgray_q == {~rgray_s_i[AW:AW-1], rgray_s_i[AW-2:0]});
  assign afull_o = (free <= {1'b0, af_ofs_q});
  assign half_o  = (used >= HALF_V);

  // offset load sequencer
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= OFS_AE_LO;
      ae_ofs_q <= AW'(DEF_OFS);
      af_ofs_q <= AW'(DEF_OFS);
    end else if (!ld_i) begin
      sel_q <= OFS_AE_LO;
    end else if (wen_i) begin
      case (sel_q)
        OFS_AE_LO: begin
          ae_ofs_q[LO_W-1:0] <= ofs_data_i[LO_W-1:0];
          sel_q              <= OFS_AE_HI;
        end
        OFS_AE_HI: begin
          ae_ofs_q[AW-1:LO_W] <= ofs_data_i;
          sel_q               <= OFS_AF_LO;
        end
        OFS_AF_LO: begin
          af_ofs_q[LO_W-1:0] <= ofs_data_i[LO_W-1:0];
          sel_q              <= OFS_AF_HI;
        end
        default: begin
          af_ofs_q[AW-1:LO_W] <= ofs_data_i;
          sel_q               <= OFS_AE_LO;
        end
      endcase
    end
  end

  assign we_o     = push;
  assign waddr_o  = wbin_q[AW-1:0];
  assign wgray_o  = wgray_q;
  assign ae_ofs_o = ae_ofs_q;
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side #(
  parameter int AW = 8
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] ae_ofs_i,
  output logic          re_o,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic          empty_o,
  output logic          aempty_o
);
  logic [AW:0] rbin_q, rgray_q, rbin_nxt, wbin_s, used;
  logic        pop;

  assign pop      = ren_i & ~empty_o;
  assign rbin_nxt = rbin_q + (AW+1)'(pop);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  always_comb begin
    for (int i = 0; i <= AW; i++) wbin_s[i] = ^(wgray_s_i >> i);
  end

  assign used     = wbin_s - rbin_q;
  assign empty_o  = (rgray_q == wgray_s_i);
  assign aempty_o = (used <= {1'b0, ae_ofs_i});
  assign re_o     = pop;
  assign raddr_o  = rbin_q[AW-1:0];
  assign rgray_o  = rgray_q;
endmodule

// File: rtl/dcfifo_pflag.sv
`timescale 1ns/1ps
module dcfifo_pflag #(
  parameter int DATA_W  = 18,
  parameter int DEPTH   = 256,
  parameter int DEF_OFS = 7,
  parameter int SYNC_N  = 2
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wen_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ren_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              afull_o,
  output logic              aempty_o,
  output logic              half_o
);
  localparam int AW   = $clog2(DEPTH);
  localparam int LO_W = AW / 2;
  localparam int HI_W = AW - LO_W;

  logic              we, re;
  logic [AW-1:0]     waddr, raddr, ae_ofs;
  logic [AW:0]       wgray, rgray, wgray_s, rgray_s;
  logic [DATA_W-1:0] rdata_q;

  dcf_wr_side #(.AW(AW), .DEF_OFS(DEF_OFS)) u_wr (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .wen_i      (wen_i),
    .ld_i       (ld_i),
    .ofs_data_i (wdata_i[HI_W-1:0]),
    .rgray_s_i  (rgray_s),
    .we_o       (we),
    .waddr_o    (waddr),
    .wgray_o    (wgray),
    .ae_ofs_o   (ae_ofs),
    .full_o     (full_o),
    .afull_o    (afull_o),
    .half_o     (half_o)
  );

  dcf_rd_side #(.AW(AW)) u_rd (
    .rclk_i    (rclk_i),
    .rst_ni    (rst_ni),
    .ren_i     (ren_i),
    .wgray_s_i (wgray_s),
    .ae_ofs_i  (ae_ofs),
    .re_o      (re),
    .raddr_o   (raddr),
    .rgray_o   (rgray),
    .empty_o   (empty_o),
    .aempty_o  (aempty_o)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_N)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wgray),
    .q_o    (wgray_s)
  );

  dcf_sync #(.W(AW+1), .STAGES(SYNC_N)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rgray),
    .q_o    (rgray_s)
  );

  dcf_ram #(.DW(DATA_W), .AW(AW)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .rclk_i  (rclk_i),
    .rst_ni  (rst_ni),
    .re_i    (re),
    .raddr_i (raddr),
    .rdata_o (rdata_q)
  );

  assign rdata_o    = oe_i ? rdata_q : '0;
  assign rdata_oe_o = oe_i;
endmodule

// File: rtl/dcfifo_pflag_chk.sv
`timescale 1ns/1ps
module dcfifo_pflag_chk #(
  parameter int AW     = 8,
  parameter int DATA_W = 18
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              wen_i,
  input logic              ld_i,
  input logic              ren_i,
  input logic              oe_i,
  input logic              full_o,
  input logic              empty_o,
  input logic              afull_o,
  input logic              aempty_o,
  input logic              half_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [DATA_W-1:0] rdata_q,
  input logic [AW-1:0]     waddr,
  input logic [AW-1:0]     raddr
);
  a_r3_no_overflow: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && wen_i |=> $stable(waddr));

  a_r4_no_underflow: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o && ren_i |=> $stable(raddr) && $stable(rdata_q));

  a_r9_load_no_store: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(waddr));

  a_r7_full_is_afull: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> afull_o);

  a_r8_full_is_half: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> half_o);

  a_r6_empty_is_aempty: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> aempty_o);

  a_r10_bus_quiet: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !oe_i |-> rdata_o == '0);
endmodule

bind dcfifo_pflag dcfifo_pflag_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .wen_i    (wen_i),
  .ld_i     (ld_i),
  .ren_i    (ren_i),
  .oe_i     (oe_i),
  .full_o   (full_o),
  .empty_o  (empty_o),
  .afull_o  (afull_o),
  .aempty_o (aempty_o),
  .half_o   (half_o),
  .rdata_o  (rdata_o),
  .rdata_q  (rdata_q),
  .waddr    (waddr),
  .raddr    (raddr)
);

// File: tb/dcfifo_pflag_tb.sv
`timescale 1ns/1ps
module dcfifo_pflag_tb;
  localparam int DW    = 18;
  localparam int DEPTH = 256;

  logic wclk_i = 0, rclk_i = 0, rst_ni = 0;
  logic wen_i = 0, ld_i = 0, ren_i = 0, oe_i = 1;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rdata_oe_o, full_o, empty_o, afull_o, aempty_o, half_o;

  always #5 wclk_i = ~wclk_i;  // 100 MHz write clock
  always #7 rclk_i = ~rclk_i;  // unrelated read clock

  dcfifo_pflag #(.DATA_W(DW), .DEPTH(DEPTH)) u_dut (
    .wclk_i, .rclk_i, .rst_ni, .wen_i, .ld_i, .wdata_i, .ren_i, .oe_i,
    .rdata_o, .rdata_oe_o, .full_o, .empty_o, .afull_o, .aempty_o, .half_o
  );

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] last_rd = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge rclk_i);
    repeat (5) @(posedge wclk_i);
    #1;
  endtask

  task automatic wr(input logic [DW-1:0] d, input bit store);
    @(negedge wclk_i);
    wen_i = 1; wdata_i = d;
    if (store) exp_q.push_back(d);
    @(negedge wclk_i);
    wen_i = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int i);
    return DW'(i * 37 + 5) ^ DW'(i << 9);
  endfunction

  task automatic wr_n(input int n, input int base);
    for (int i = 0; i < n; i++) wr(pat(base + i), 1'b1);
  endtask

  task automatic rd_n(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk_i);
      ren_i = 1;
      @(negedge rclk_i);
      ren_i = 0;
      last_rd = exp_q.pop_front();
      chk(req, rdata_o, last_rd);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 empty", empty_o, 1);
    chk("R1 aempty", aempty_o, 1);
    chk("R1 full", full_o, 0);
    chk("R1 afull", afull_o, 0);
    chk("R1 half", half_o, 0);
  endtask

  task automatic t_order();
    wr(18'h3FFFF, 1); wr(18'h00000, 1); wr(18'h2AAAA, 1); wr(18'h15555, 1); wr(18'h00001, 1);
    settle();
    chk("R5 not empty", empty_o, 0);
    rd_n(5, "R2 order");
    wr_n(20, 100);
    settle();
    rd_n(20, "R2 order counter");
    settle();
    chk("R5 empty after drain", empty_o, 1);
  endtask

  task automatic t_empty_read();
    @(negedge rclk_i); ren_i = 1;
    repeat (3) @(negedge rclk_i);
    ren_i = 0;
    chk("R4 data held", rdata_o, last_rd);
    settle();
    chk("R4 still empty", empty_o, 1);
  endtask

  task automatic t_ae_bound();
    wr_n(7, 200); settle();
    chk("R6 count 7 ae", aempty_o, 1);
    wr_n(1, 207); settle();
    chk("R6 count 8 ae", aempty_o, 0);
    rd_n(8, "R2 drain ae");
    settle();
  endtask

  task automatic t_fill();
    wr_n(127, 300); settle();
    chk("R8 127 half", half_o, 0);
    wr_n(1, 427); settle();
    chk("R8 128 half", half_o, 1);
    wr_n(120, 428); settle();
    chk("R7 248 afull", afull_o, 0);
    wr_n(1, 548); settle();
    chk("R7 249 afull", afull_o, 1);
    chk("R5 249 full", full_o, 0);
    wr_n(7, 549); settle();
    chk("R5 256 full", full_o, 1);
    wr(18'h0BEEF, 1'b0);
    settle();
    chk("R3 still full", full_o, 1);
    rd_n(DEPTH, "R3 drain after overflow");
    settle();
    chk("R3 empty after 256 reads", empty_o, 1);
    chk("R8 half after drain", half_o, 0);
  endtask

  task automatic t_load();
    @(negedge wclk_i); ld_i = 1;
    wr(18'd3, 0); wr(18'd0, 0); wr(18'd2, 0); wr(18'd0, 0);
    @(negedge wclk_i); ld_i = 0;
    settle();
    chk("R9 load stores no data", empty_o, 1);
    wr_n(3, 600); settle();
    chk("R9 ae ofs 3 at 3", aempty_o, 1);
    wr_n(1, 603); settle();
    chk("R9 ae ofs 3 at 4", aempty_o, 0);
    wr_n(249, 604); settle();
    chk("R7 af ofs 2 at 253", afull_o, 0);
    wr_n(1, 853); settle();
    chk("R7 af ofs 2 at 254", afull_o, 1);
    rd_n(254, "R2 drain load");
    settle();
  endtask

  task automatic t_load_restart();
    @(negedge wclk_i); ld_i = 1;
    wr(18'd5, 0); wr(18'd0, 0);
    @(negedge wclk_i); ld_i = 0;
    @(negedge wclk_i); ld_i = 1;
    wr(18'd2, 0);
    @(negedge wclk_i); ld_i = 0;
    wr_n(2, 900); settle();
    chk("R9 restart ae ofs 2 at 2", aempty_o, 1);
    wr_n(1, 902); settle();
    chk("R9 restart ae ofs 2 at 3", aempty_o, 0);
    rd_n(3, "R2 drain restart");
    settle();
  endtask

  task automatic t_async();
    int got = 0;
    bit pend = 0;
    logic [DW-1:0] e;
    fork
      wr_n(60, 1000);
      begin
        while (got < 60) begin
          @(negedge rclk_i);
          if (pend) begin
            e = exp_q.pop_front();
            last_rd = e;
            chk("R11 concurrent order", rdata_o, e);
            got++;
          end
          pend = !empty_o && (got < 60);
          ren_i = pend;
        end
        ren_i = 0;
      end
    join
    settle();
    chk("R11 empty after stream", empty_o, 1);
  endtask

  task automatic t_oe();
    @(negedge rclk_i); oe_i = 0; #1;
    chk("R10 bus zero", rdata_o, 0);
    chk("R10 oe low", rdata_oe_o, 0);
    @(negedge rclk_i); oe_i = 1; #1;
    chk("R10 bus restored", rdata_o, last_rd);
    chk("R10 oe high", rdata_oe_o, 1);
  endtask

  initial begin
    #43 rst_ni = 1;
    t_reset();
    t_order();
    t_empty_read();
    t_ae_bound();
    t_fill();
    t_load();
    t_load_restart();
    t_async();
    t_oe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule